// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Register

This block is the device-side command front end of a synchronous DRAM. On every rising clock edge it samples the chip select, the three command strobes (row select, column select and write enable), the bank inputs and the address. It classifies the cycle as one of seven command kinds and reports the result one clock later. It also keeps the programmed mode register and tracks, for every bank, whether that bank holds an open row and how many clocks have passed since the row was opened.

The decoder enforces the ordering rules around the mode register and row access. It refuses a mode write while any bank is open. It refuses a mode write that carries a reserved encoding. It refuses row activates until a valid mode has been written once. It rejects column commands that reach a bank which is closed, or which is still inside its row-to-column delay. Each rejection raises a one-cycle error pulse, and a rejected command leaves the state unchanged. The row-to-column delay is supplied in clocks on a configuration input. Downstream logic reads the decoded command, the mode fields and the bank-open vector directly from the ports.

Top module: `sdram_cmd_front`

## Requirements
- R1: While chipSelN is high the cycle decodes as NOP (cmdKind 0, cmdBank 0), whatever the other pins carry, and neither the mode nor the bank state changes.
- R2: With chipSelN low, the levels {rowSelN,colSelN,wrEnN} decode as follows: 011 to activate (1), 101 to read (2), 100 to write (3), 010 to precharge (4), 001 to refresh (5) and 000 to mode set (6); any other level combination decodes as NOP (0). The result appears on cmdKind in the cycle after the sampling edge. For any non-NOP command, cmdBank carries the sampled bank; otherwise it is 0.
- R3: An accepted mode set loads the burst length code from addrIn[2:0], the burst type from addrIn[3] (1 = interleaved), the CAS latency from addrIn[6:4] and the write mode from addrIn[9] (1 = single write).
- R4: A mode set that arrives while any bank is open is rejected: the mode stays unchanged and errModeOpen pulses for one cycle.
- R5: With all banks closed, a mode set is rejected with an errModeReserved pulse, and the mode stays unchanged, if any of these holds: the burst length code is 4, 5 or 6; the code is 7 (full page) together with interleaved type; or the CAS latency is neither 2 nor 3.
- R6: An activate that arrives before the first accepted mode set after reset is rejected: errActEarly pulses and the bank stays closed.
- R7: After the first accepted mode set, an activate opens the addressed bank. A precharge closes the addressed bank, or closes every bank when addrIn[10] is high.
- R8: A read or write is rejected with an errColumn pulse if its bank is closed, or if fewer than rcdClocks clocks have passed since that bank's activate. The elapsed count saturates at 15, and rcdClocks of 0 behaves like 1.
- R9: The mode register can be rewritten any number of times. Each accepted mode set replaces all four fields.
- R10: After reset the bank state is all closed, all mode fields are 0, cmdKind is NOP and all error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rcdClocks | input | 4 | Minimum clocks from activate to column command |
| chipSelN | input | 1 | Chip select, active low |
| rowSelN | input | 1 | Row strobe, active low |
| colSelN | input | 1 | Column strobe, active low |
| wrEnN | input | 1 | Write enable, active low |
| bankIn | input | 2 | Bank address |
| addrIn | input | 13 | Address; carries mode fields on a mode set and the all-banks bit on a precharge |
| cmdKind | output | 3 | Decoded command of the previous edge |
| cmdBank | output | 2 | Bank of the previous command, 0 for NOP |
| burstLen | output | 3 | Mode: burst length code |
| burstInterleave | output | 1 | Mode: 1 = interleaved burst order |
| casLatency | output | 3 | Mode: CAS latency in clocks |
| singleWrite | output | 1 | Mode: 1 = burst read with single write |
| bankOpen | output | 4 | One bit per bank, high while that bank's row is open |
| errModeOpen | output | 1 | Pulse: mode set refused because a bank is open |
| errModeReserved | output | 1 | Pulse: mode set refused because of a reserved encoding |
| errActEarly | output | 1 | Pulse: activate refused because no mode has been set |
| errColumn | output | 1 | Pulse: read or write to a closed or not-yet-ready bank |

## Verification
A wrong bank-open bit shows on bankOpen one clock after the command that corrupted it. It then shows again as a wrong errModeOpen or errColumn pulse on the next mode set or column access to that bank. A wrong elapsed-clock counter can stay hidden until a column command lands exactly at the row-to-column boundary, so the bench sweeps rcdClocks and places column commands at offsets on both sides of that boundary. A lost "mode seen" flag, or a mode register written on a rejected command, shows on the mode outputs or on errActEarly within one clock of the next relevant command.

// File: rtl/sdram_front_pkg.sv
package sdram_front_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  typedef struct packed {
    logic [2:0] burstLen;
    logic       interleave;
    logic [2:0] casLat;
    logic       singleWrite;
  } mode_t;

  // strobes from control to datapath, all evaluated for the current edge
  typedef struct packed {
    cmd_e kind;
    logic loadMode;
    logic openSel;
    logic closeSel;
    logic closeAll;
    logic errModeOpen;
    logic errModeRes;
    logic errActEarly;
    logic errColumn;
  } strobe_t;

  // address positions the decoder depends on
  localparam int BL_LSB       = 0;
  localparam int BT_BIT       = 3;
  localparam int CL_LSB       = 4;
  localparam int WM_BIT       = 9;
  localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_front_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipSelN,
  input  logic                 rowSelN,
  input  logic                 colSelN,
  input  logic                 wrEnN,
  input  logic [BANK_W-1:0]    bankIn,
  input  logic [2:0]           blCode,
  input  logic                 btBit,
  input  logic [2:0]           clCode,
  input  logic                 allBanks,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] bankReady,
  input  logic                 modeSeen,
  output strobe_t              strobe
);

  cmd_e kind;
  logic codeBad;

  always_comb begin
    kind = CMD_NOP;
    if (!chipSelN) begin
      case ({rowSelN, colSelN, wrEnN})
        3'b011:  kind = CMD_ACT;
        3'b101:  kind = CMD_RD;
        3'b100:  kind = CMD_WR;
        3'b010:  kind = CMD_PRE;
        3'b001:  kind = CMD_REF;
        3'b000:  kind = CMD_MRS;
        default: kind = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    codeBad = 1'b0;
    if (blCode inside {3'd4, 3'd5, 3'd6}) codeBad = 1'b1;
    if (blCode == 3'd7 && btBit) codeBad = 1'b1;
    if (!(clCode inside {3'd2, 3'd3})) codeBad = 1'b1;
  end

  always_comb begin
    strobe      = '0;
    strobe.kind = kind;
    case (kind)
      CMD_ACT: begin
        if (!modeSeen) strobe.errActEarly = 1'b1;
        else           strobe.openSel     = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (!bankReady[bankIn]) strobe.errColumn = 1'b1;
      end
      CMD_PRE: begin
        if (allBanks) strobe.closeAll = 1'b1;
        else          strobe.closeSel = 1'b1;
      end
      CMD_MRS: begin
        if (|bankOpen)    strobe.errModeOpen = 1'b1;
        else if (codeBad) strobe.errModeRes  = 1'b1;
        else              strobe.loadMode    = 1'b1;
      end
      default: ;
    endcase
  end

  // R2: a decoded command triggers at most one action or error
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadMode, strobe.openSel, strobe.closeSel, strobe.closeAll,
              strobe.errModeOpen, strobe.errModeRes, strobe.errActEarly, strobe.errColumn}));

  // R6: no bank is opened while no mode has been accepted
  a_r6_no_open_before_mode: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSeen && strobe.kind == CMD_ACT) |-> strobe.errActEarly);

endmodule

// File: rtl/sdram_cmd_dp.sv
module sdram_cmd_dp
  import sdram_front_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     rcdClocks,
  input  strobe_t              strobe,
  input  logic [BANK_W-1:0]    bankIn,
  input  mode_t                newMode,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankReady,
  output logic                 modeSeen,
  output mode_t                mode,
  output logic [2:0]           cmdKind,
  output logic [BANK_W-1:0]    cmdBank,
  output logic                 errModeOpen,
  output logic                 errModeRes,
  output logic                 errActEarly,
  output logic                 errColumn
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             openR [NUM_BANKS];
  logic [CNT_W-1:0] cntR  [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic isSel;
    assign isSel = (bankIn == BANK_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openR[g] <= 1'b0;
        cntR[g]  <= '0;
      end else if (strobe.openSel && isSel) begin
        openR[g] <= 1'b1;
        cntR[g]  <= CNT_W'(1);
      end else begin
        if (strobe.closeAll || (strobe.closeSel && isSel)) openR[g] <= 1'b0;
        if (cntR[g] != CNT_MAX) cntR[g] <= cntR[g] + CNT_W'(1);
      end
    end

    assign bankOpen[g]  = openR[g];
    assign bankReady[g] = openR[g] && (cntR[g] >= rcdClocks);
  end

  mode_t modeR;
  logic  modeSeenR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR       <= '0;
      modeSeenR   <= 1'b0;
      cmdKind     <= CMD_NOP;
      cmdBank     <= '0;
      errModeOpen <= 1'b0;
      errModeRes  <= 1'b0;
      errActEarly <= 1'b0;
      errColumn   <= 1'b0;
    end else begin
      if (strobe.loadMode) begin
        modeR     <= newMode;
        modeSeenR <= 1'b1;
      end
      cmdKind     <= strobe.kind;
      cmdBank     <= (strobe.kind != CMD_NOP) ? bankIn : '0;
      errModeOpen <= strobe.errModeOpen;
      errModeRes  <= strobe.errModeRes;
      errActEarly <= strobe.errActEarly;
      errColumn   <= strobe.errColumn;
    end
  end

  assign mode     = modeR;
  assign modeSeen = modeSeenR;

  // R3: the mode only moves on an accepted mode set
  a_r3_mode_only_on_mrs: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeR) |-> (cmdKind == CMD_MRS && !errModeOpen && !errModeRes));

  // R4: a mode set refused for an open bank leaves the mode alone
  a_r4_open_reject_keeps_mode: assert property (@(posedge clk) disable iff (!rstN)
    errModeOpen |-> $stable(modeR));

  // R5: a reserved encoding leaves the mode alone
  a_r5_reserved_keeps_mode: assert property (@(posedge clk) disable iff (!rstN)
    errModeRes |-> $stable(modeR));

  // R6: a refused early activate opens nothing
  a_r6_early_act_no_open: assert property (@(posedge clk) disable iff (!rstN)
    errActEarly |-> ($stable(bankOpen) && !modeSeenR));

  // R8: a refused column command does not touch bank state
  a_r8_column_reject_stable: assert property (@(posedge clk) disable iff (!rstN)
    errColumn |-> $stable(bankOpen));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_front_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W = 13,
  parameter int CNT_W = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     rcdClocks,
  input  logic                 chipSelN,
  input  logic                 rowSelN,
  input  logic                 colSelN,
  input  logic                 wrEnN,
  input  logic [BANK_W-1:0]    bankIn,
  input  logic [ADDR_W-1:0]    addrIn,
  output logic [2:0]           cmdKind,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [2:0]           burstLen,
  output logic                 burstInterleave,
  output logic [2:0]           casLatency,
  output logic                 singleWrite,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 errModeOpen,
  output logic                 errModeReserved,
  output logic                 errActEarly,
  output logic                 errColumn
);

  mode_t                newMode;
  mode_t                mode;
  strobe_t              strobe;
  logic [NUM_BANKS-1:0] bankReady;
  logic                 modeSeen;
  logic                 unusedAddr;

  assign newMode.burstLen    = addrIn[BL_LSB +: 3];
  assign newMode.interleave  = addrIn[BT_BIT];
  assign newMode.casLat      = addrIn[CL_LSB +: 3];
  assign newMode.singleWrite = addrIn[WM_BIT];
  assign unusedAddr = ^{addrIn[ADDR_W-1:ALL_BANK_BIT+1], addrIn[WM_BIT-1:CL_LSB+3]};

  sdram_cmd_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSelN (chipSelN),
    .rowSelN  (rowSelN),
    .colSelN  (colSelN),
    .wrEnN    (wrEnN),
    .bankIn   (bankIn),
    .blCode   (newMode.burstLen),
    .btBit    (newMode.interleave),
    .clCode   (newMode.casLat),
    .allBanks (addrIn[ALL_BANK_BIT]),
    .bankOpen (bankOpen),
    .bankReady(bankReady),
    .modeSeen (modeSeen),
    .strobe   (strobe)
  );

  sdram_cmd_dp #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rcdClocks  (rcdClocks),
    .strobe     (strobe),
    .bankIn     (bankIn),
    .newMode    (newMode),
    .bankOpen   (bankOpen),
    .bankReady  (bankReady),
    .modeSeen   (modeSeen),
    .mode       (mode),
    .cmdKind    (cmdKind),
    .cmdBank    (cmdBank),
    .errModeOpen(errModeOpen),
    .errModeRes (errModeReserved),
    .errActEarly(errActEarly),
    .errColumn  (errColumn)
  );

  assign burstLen        = mode.burstLen;
  assign burstInterleave = mode.interleave;
  assign casLatency      = mode.casLat;
  assign singleWrite     = mode.singleWrite;

  // R1: a deselected cycle reports NOP and changes no bank
  a_r1_deselect_nop: assert property (@(posedge clk) disable iff (!rstN)
    $past(chipSelN) |-> (cmdKind == 3'd0 && cmdBank == '0));

endmodule

// File: tb/sdram_cmd_front_bench.sv
`timescale 1ns/1ps
module sdram_cmd_front_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rcdClocks = 4'd3;
  logic        chipSelN = 1'b1, rowSelN = 1'b1, colSelN = 1'b1, wrEnN = 1'b1;
  logic [1:0]  bankIn = '0;
  logic [12:0] addrIn = '0;
  logic [2:0]  cmdKind;
  logic [1:0]  cmdBank;
  logic [2:0]  burstLen, casLatency;
  logic        burstInterleave, singleWrite;
  logic [3:0]  bankOpen;
  logic        errModeOpen, errModeReserved, errActEarly, errColumn;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_cmd_front u_sdram_cmd_front (
    .clk(clk), .rstN(rstN), .rcdClocks(rcdClocks),
    .chipSelN(chipSelN), .rowSelN(rowSelN), .colSelN(colSelN), .wrEnN(wrEnN),
    .bankIn(bankIn), .addrIn(addrIn),
    .cmdKind(cmdKind), .cmdBank(cmdBank), .burstLen(burstLen),
    .burstInterleave(burstInterleave), .casLatency(casLatency),
    .singleWrite(singleWrite), .bankOpen(bankOpen),
    .errModeOpen(errModeOpen), .errModeReserved(errModeReserved),
    .errActEarly(errActEarly), .errColumn(errColumn)
  );

  // reference state
  logic [7:0] mMode;   // {bl[2:0], bt, cl[2:0], wm}
  logic       mSeen;
  logic [3:0] mOpen;
  logic [3:0] mCnt [4];
  logic [2:0] eKind;
  logic [1:0] eBank;
  logic       eMo, eRes, eAct, eCol;

  function automatic logic [2:0] decodeKind(logic cs, logic r, logic c, logic w);
    if (cs) return 3'd0;
    case ({r, c, w})
      3'b011: return 3'd1;
      3'b101: return 3'd2;
      3'b100: return 3'd3;
      3'b010: return 3'd4;
      3'b001: return 3'd5;
      3'b000: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic modeIsBad(logic [12:0] a);
    logic [2:0] bl = a[2:0];
    logic [2:0] cl = a[6:4];
    if (bl == 3'd4 || bl == 3'd5 || bl == 3'd6) return 1'b1;
    if (bl == 3'd7 && a[3]) return 1'b1;
    if (cl != 3'd2 && cl != 3'd3) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelEdge();
    logic [2:0] k = decodeKind(chipSelN, rowSelN, colSelN, wrEnN);
    int b = bankIn;
    logic actDone = 1'b0;
    eKind = k; eBank = (k != 3'd0) ? bankIn : 2'd0;
    eMo = 0; eRes = 0; eAct = 0; eCol = 0;
    case (k)
      3'd1: if (!mSeen) eAct = 1; else begin mOpen[b] = 1'b1; actDone = 1'b1; end
      3'd2, 3'd3: if (!(mOpen[b] && mCnt[b] >= rcdClocks)) eCol = 1;
      3'd4: if (addrIn[10]) mOpen = '0; else mOpen[b] = 1'b0;
      3'd6: begin
        if (|mOpen) eMo = 1;
        else if (modeIsBad(addrIn)) eRes = 1;
        else begin mMode = {addrIn[2:0], addrIn[3], addrIn[6:4], addrIn[9]}; mSeen = 1; end
      end
      default: ;
    endcase
    for (int i = 0; i < 4; i++) begin
      if (actDone && i == b) mCnt[i] = 4'd1;
      else if (mCnt[i] != 4'hf) mCnt[i] = mCnt[i] + 4'd1;
    end
  endtask

  task automatic compareAll();
    chk("R2 cmdKind", cmdKind, eKind);
    chk("R2 cmdBank", cmdBank, eBank);
    chk("R3 mode", {burstLen, burstInterleave, casLatency, singleWrite}, mMode);
    chk("R7 bankOpen", bankOpen, mOpen);
    chk("R4 errModeOpen", errModeOpen, eMo);
    chk("R5 errModeReserved", errModeReserved, eRes);
    chk("R6 errActEarly", errActEarly, eAct);
    chk("R8 errColumn", errColumn, eCol);
  endtask

  // drive at negedge, model at posedge, compare 1 ns later, return at negedge
  task automatic step(logic cs, logic r, logic c, logic w, logic [1:0] bk, logic [12:0] a);
    chipSelN = cs; rowSelN = r; colSelN = c; wrEnN = w; bankIn = bk; addrIn = a;
    @(posedge clk);
    modelEdge();
    #1;
    compareAll();
    @(negedge clk);
  endtask

  task automatic nop();            step(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 13'd0); endtask
  task automatic act(int bk);      step(1'b0, 1'b0, 1'b1, 1'b1, 2'(bk), 13'd5); endtask
  task automatic rd(int bk);       step(1'b0, 1'b1, 1'b0, 1'b1, 2'(bk), 13'd0); endtask
  task automatic wr(int bk);       step(1'b0, 1'b1, 1'b0, 1'b0, 2'(bk), 13'd0); endtask
  task automatic pre(int bk, logic all); step(1'b0, 1'b0, 1'b1, 1'b0, 2'(bk), {2'b0, all, 10'd0}); endtask
  task automatic mrs(logic [12:0] a); step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, a); endtask

  function automatic logic [12:0] modeAddr(int bl, int bt, int cl, int wm);
    return {3'b0, 1'(wm), 2'b0, 3'(cl), 1'(bt), 3'(bl)};
  endfunction

  initial begin
    mMode = '0; mSeen = 0; mOpen = '0;
    for (int i = 0; i < 4; i++) mCnt[i] = '0;
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state
    chk("R10 kind", cmdKind, 0);
    chk("R10 banks", bankOpen, 0);
    chk("R10 mode", {burstLen, burstInterleave, casLatency, singleWrite}, 0);
    chk("R10 errs", {errModeOpen, errModeReserved, errActEarly, errColumn}, 0);
    @(negedge clk);

    nop();
    act(2);                                  // R6: too early
    chk("R6 early act flagged", errActEarly, 1);
    chk("R6 bank stays closed", bankOpen, 0);
    mrs(modeAddr(5, 0, 2, 0));               // R5: bad length
    chk("R5 length 5", errModeReserved, 1);
    mrs(modeAddr(2, 0, 1, 0));               // R5: bad latency
    chk("R5 latency 1", errModeReserved, 1);
    mrs(modeAddr(7, 1, 3, 0));               // R5: full page interleaved
    chk("R5 full page interleaved", errModeReserved, 1);
    chk("R5 mode unchanged", {burstLen, burstInterleave, casLatency, singleWrite}, 0);
    mrs(modeAddr(3, 0, 2, 1));               // R3: accepted
    chk("R3 loaded", {burstLen, burstInterleave, casLatency, singleWrite}, {3'd3, 1'b0, 3'd2, 1'b1});
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, modeAddr(1, 1, 3, 0)); // R1: deselected mode set
    chk("R1 deselect is NOP", cmdKind, 0);
    chk("R1 mode untouched", {burstLen, burstInterleave, casLatency, singleWrite}, {3'd3, 1'b0, 3'd2, 1'b1});
    rcdClocks = 4'd3;
    act(1);
    chk("R7 bank 1 open", bankOpen, 4'b0010);
    rd(1);                                   // R8: one clock after activate
    chk("R8 early read", errColumn, 1);
    nop();
    wr(1);                                   // three clocks: legal
    chk("R8 write at boundary", errColumn, 0);
    mrs(modeAddr(1, 1, 3, 0));               // R4: bank open
    chk("R4 refused", errModeOpen, 1);
    act(3);
    pre(1, 1'b1);                            // R7: precharge all
    chk("R7 all closed", bankOpen, 0);
    mrs(modeAddr(1, 1, 3, 0));               // R9: rewrite
    chk("R9 rewritten", {burstLen, burstInterleave, casLatency, singleWrite}, {3'd1, 1'b1, 3'd3, 1'b0});
    wr(0);
    chk("R8 closed bank", errColumn, 1);
    act(0); act(2); pre(0, 1'b0);
    chk("R7 single close", bankOpen, 4'b0100);
    rcdClocks = 4'd0;
    act(0); rd(0);
    chk("R8 rcd 0 acts as 1", errColumn, 0);
    pre(0, 1'b1);

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 16;
      logic [12:0] a = 13'($urandom);
      logic [1:0] bk = 2'($urandom);
      if (n % 500 == 0) rcdClocks = 4'($urandom % 6);
      if (r < 2)       step(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), bk, a);
      else if (r < 5)  step(1'b0, 1'b0, 1'b1, 1'b1, bk, a);
      else if (r < 7)  step(1'b0, 1'b1, 1'b0, 1'b1, bk, a);
      else if (r < 8)  step(1'b0, 1'b1, 1'b0, 1'b0, bk, a);
      else if (r < 10) step(1'b0, 1'b0, 1'b1, 1'b0, bk, a);
      else if (r < 11) step(1'b0, 1'b0, 1'b0, 1'b1, bk, a);
      else if (r < 13) begin
        if ($urandom % 2 == 0) a = {a[12:10], 1'($urandom), a[8:7], 3'(2 + $urandom % 2), 1'($urandom), 3'($urandom % 4)};
        step(1'b0, 1'b0, 1'b0, 1'b0, bk, a);
      end
      else if (r < 14) step(1'b0, 1'b1, 1'b1, 1'b0, bk, a);
      else             step(1'b0, 1'b1, 1'b1, 1'b1, bk, a);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule